// File: doc/BRIEF.md
# Phase Comparator with Lock Monitor

This block is the digital phase/frequency comparator for one synthesizer loop. It watches two divided clocks: the reference (`ref_in`) and the divided oscillator feedback (`fb_in`). Each rising edge on one of them arms a request flag. When the other input rises, both flags drop together. The flag set by the earlier edge is presented as a pump request for as many clock cycles as the two edges are apart. A polarity input swaps the up and down requests, so the block can serve loops whose oscillator tunes in either direction.

A lock monitor measures how long each pump pulse lasts. After a set number of reference edges with no pulse wider than a limit, it raises a lock flag. It drops the flag in the same cycle in which a pulse grows past the limit. One shared output pin carries either the lock flag or, in monitor mode, one of the two raw comparator inputs. A second select bit picks which input. A power-save input clears all comparator state, silences both pump requests and disables the pump.

The inputs are assumed synchronous to `clk`, and each divided clock is assumed to stay high and low for at least one clock cycle. The block reads each input once per cycle and detects edges from that sample.

Top module: `pfd_lock_top`

## Requirements
- R1: After a synchronous active-low reset with `sleep` low, `pump_up` and `pump_dn` are 0, `pump_en` is 1, and `shared_out` (lock view) is 0.
- R2: With `invert` = 0, a rising edge of `ref_in` seen at clock edge k makes `pump_up` 1 from edge k until edge k+d, where `fb_in` rises at edge k+d. That is a pulse exactly d cycles wide.
- R3: With `invert` = 0, when `fb_in` rises d cycles before `ref_in`, `pump_dn` is high for d cycles. Rises seen at the same clock edge give no pulse. `pump_up` and `pump_dn` are never 1 together.
- R4: With `invert` = 1, the two requests swap: a leading `ref_in` drives `pump_dn`, and a leading `fb_in` drives `pump_up`. Pulse widths are unchanged.
- R5: While `sleep` = 1, `pump_up`, `pump_dn` and `pump_en` are 0. Any pulse in progress is discarded, and edges seen during sleep produce no pulse after wake-up.
- R6: Lock (`shared_out` with `mon_sel` = 0) becomes 1 at the clock edge that sees the LOCK_COUNT-th (default 4) reference rising edge since reset, wake-up or the last over-wide pulse.
- R7: A pump pulse that stays high for more than MAX_W (default 4) cycles clears lock and the edge count. This happens at the edge that ends its (MAX_W+1)-th cycle.
- R8: Asserting `sleep` clears lock by the next clock edge.
- R9: With `mon_sel` = 1, `shared_out` follows `ref_in` when `mon_src` = 0 and `fb_in` when `mon_src` = 1, with no clock delay. With `mon_sel` = 0 it shows lock.
- R10: A pulse exactly MAX_W cycles wide leaves lock set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Divided reference clock |
| fb_in | input | 1 | Divided feedback clock |
| invert | input | 1 | 1 swaps up and down requests |
| sleep | input | 1 | Power-save: clears state, silences pump |
| mon_sel | input | 1 | 1 = shared pin shows a raw input, 0 = lock |
| mon_src | input | 1 | Monitor choice: 0 = ref_in, 1 = fb_in |
| pump_up | output | 1 | Up request to charge pump |
| pump_dn | output | 1 | Down request to charge pump |
| pump_en | output | 1 | 0 = pump output held in high impedance |
| shared_out | output | 1 | Lock flag or monitored input |

## Verification
The hardest state to reach from the ports is a lock flag that is set and then broken by a single pulse just one cycle past the width limit. The stimulus first builds lock with a run of narrow pulses. It then sends a pulse exactly at the limit, which must keep lock, and then one a cycle wider, which must drop it. Discarding a half-finished pulse on power-save is reached the same way: the bench raises `sleep` one cycle after a lone reference edge, while the up request is still open.

// File: rtl/pfd_pkg.sv
// pfd_pkg: shared types for the phase comparator.
// Assumes nothing beyond the 1800-2017 language.
package pfd_pkg;

    // Source shown on the shared output pin.
    typedef enum logic [1:0] {
        PIN_LOCK = 2'd0,
        PIN_REF  = 2'd1,
        PIN_FB   = 2'd2
    } pin_src_e;

    // Decode the two select inputs into a pin source.
    function automatic pin_src_e pick_src(input logic mon_sel, input logic mon_src);
        if (!mon_sel)
            return PIN_LOCK;
        else if (mon_src)
            return PIN_FB;
        else
            return PIN_REF;
    endfunction

endpackage

// File: rtl/pfd_edge.sv
// pfd_edge: rising-edge detector for one input synchronous to clk.
// Assumes the input is already in the clk domain. It keeps sampling
// during power-save, so a level held across wake-up is not seen as an edge.
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sig;
    end

    assign rise = sig & ~prev_q;

endmodule

// File: rtl/pfd_flags.sv
// pfd_flags: the two request flags of the phase/frequency comparator.
// A flag is set by its own rising edge. Both clear together once both
// would be set. Assumes edge pulses last one cycle.
module pfd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic rise_ref,
    input  logic rise_fb,
    output logic ref_flag,
    output logic fb_flag
);

    logic next_ref;
    logic next_fb;

    // Candidate flag values before the mutual-clear rule.
    always_comb begin
        next_ref = ref_flag | rise_ref;
        next_fb  = fb_flag | rise_fb;
    end

    // Update flags; power-save clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) begin
            ref_flag <= 1'b0;
            fb_flag  <= 1'b0;
        end else if (next_ref && next_fb) begin
            ref_flag <= 1'b0;
            fb_flag  <= 1'b0;
        end else begin
            ref_flag <= next_ref;
            fb_flag  <= next_fb;
        end
    end

endmodule

// File: rtl/pfd_lock.sv
// pfd_lock: lock monitor. It measures each pump pulse in clk cycles.
// It declares lock after LOCK_COUNT reference edges with no pulse wider
// than MAX_W, and clears lock in the cycle a pulse exceeds MAX_W.
module pfd_lock #(
    parameter int unsigned MAX_W      = 4,
    parameter int unsigned LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic active,
    input  logic rise_ref,
    output logic locked
);

    localparam int WW = $clog2(MAX_W + 2);
    localparam int CW = $clog2(LOCK_COUNT + 1);

    logic [WW-1:0] width_q;
    logic [CW-1:0] good_q;
    logic          over;

    assign over = active && (width_q >= WW'(MAX_W));

    // Count cycles of the current pump pulse, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep)
            width_q <= '0;
        else if (!active)
            width_q <= '0;
        else if (width_q != WW'(MAX_W))
            width_q <= width_q + 1'b1;
    end

    // Count good reference edges and hold the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (over) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (rise_ref && (good_q != CW'(LOCK_COUNT))) begin
            good_q <= good_q + 1'b1;
            if (good_q == CW'(LOCK_COUNT - 1))
                locked <= 1'b1;
        end
    end

endmodule

// File: rtl/pfd_lock_top.sv
// pfd_lock_top: phase/frequency comparator with lock monitor and a
// shared lock/monitor pin. Assumes ref_in and fb_in are synchronous to
// clk and hold each level for at least one cycle.
module pfd_lock_top #(
    parameter int unsigned MAX_W      = 4,
    parameter int unsigned LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic invert,
    input  logic sleep,
    input  logic mon_sel,
    input  logic mon_src,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_en,
    output logic shared_out
);
    import pfd_pkg::*;

    localparam int NIN = 2;

    logic [NIN-1:0] raw;
    logic [NIN-1:0] rises;
    logic           ref_flag;
    logic           fb_flag;
    logic           lock_q;
    pin_src_e       pin_src;

    assign raw = {fb_in, ref_in};

    // One edge detector per comparator input.
    for (genvar g = 0; g < NIN; g++) begin : g_edge
        pfd_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (raw[g]),
            .rise  (rises[g])
        );
    end

    pfd_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .rise_ref (rises[0]),
        .rise_fb  (rises[1]),
        .ref_flag (ref_flag),
        .fb_flag  (fb_flag)
    );

    pfd_lock #(
        .MAX_W      (MAX_W),
        .LOCK_COUNT (LOCK_COUNT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .active   (ref_flag | fb_flag),
        .rise_ref (rises[0]),
        .locked   (lock_q)
    );

    // Pump requests with polarity swap and power-save gating.
    always_comb begin
        pump_en = ~sleep;
        pump_up = pump_en & (invert ? fb_flag  : ref_flag);
        pump_dn = pump_en & (invert ? ref_flag : fb_flag);
    end

    // Shared pin source selection.
    always_comb begin
        pin_src = pick_src(mon_sel, mon_src);
        case (pin_src)
            PIN_REF: shared_out = ref_in;
            PIN_FB:  shared_out = fb_in;
            default: shared_out = lock_q;
        endcase
    end

endmodule

// File: rtl/pfd_lock_chk.sv
// pfd_lock_chk: property checker bound to pfd_lock_top.
// It keeps its own count of pump pulse width, kept apart from the design's counter.
module pfd_lock_chk #(
    parameter int unsigned MAX_W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ref_in,
    input logic invert,
    input logic sleep,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_en,
    input logic lock_q
);

    localparam int HW = $clog2(MAX_W + 2);
    logic [HW-1:0] hi_cnt;

    // Count consecutive cycles with a pump request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !(pump_up || pump_dn))
            hi_cnt <= '0;
        else if (hi_cnt != HW'(MAX_W + 1))
            hi_cnt <= hi_cnt + 1'b1;
    end

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!pump_up && !pump_dn && !pump_en));

    a_r8_sleep_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !lock_q);

    a_r7_wide_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        ((pump_up || pump_dn) && (hi_cnt >= HW'(MAX_W))) |=> !lock_q);

    a_r2_up_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (!invert && $stable(invert) && !sleep && !$past(sleep) && $rose(pump_up))
            |-> $past(ref_in));

endmodule

bind pfd_lock_top pfd_lock_chk #(.MAX_W(MAX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_in),
    .invert  (invert),
    .sleep   (sleep),
    .pump_up (pump_up),
    .pump_dn (pump_dn),
    .pump_en (pump_en),
    .lock_q  (lock_q)
);

// File: tb/tb_pfd_lock_top.sv
`timescale 1ns/1ps
module tb_pfd_lock_top;

    localparam int MAX_W      = 4;
    localparam int LOCK_COUNT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic invert = 1'b0;
    logic sleep = 1'b0;
    logic mon_sel = 1'b0;
    logic mon_src = 1'b0;
    logic pump_up, pump_dn, pump_en, shared_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pfd_lock_top #(.MAX_W(MAX_W), .LOCK_COUNT(LOCK_COUNT)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .invert(invert), .sleep(sleep), .mon_sel(mon_sel), .mon_src(mon_src),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
        .shared_out(shared_out)
    );

    // d > 0: ref leads by d; d < 0: fb leads by -d; d = 0: together
    typedef struct packed {
        int   d;
        logic inv;
        int   up_w;
        int   dn_w;
        int   req;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ 1, 1'b0, 1, 0, 2},
        '{ 3, 1'b0, 3, 0, 2},
        '{-2, 1'b0, 0, 2, 3},
        '{ 0, 1'b0, 0, 0, 3},
        '{ 2, 1'b1, 0, 2, 4},
        '{-3, 1'b1, 3, 0, 4}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int d, output int nu, output int nd, output int both);
        int m;
        m = (d < 0) ? -d : d;
        nu = 0; nd = 0; both = 0;
        @(negedge clk);
        if (d >= 0) ref_in = 1'b1;
        if (d <= 0) fb_in = 1'b1;
        for (int k = 1; k <= m; k++) begin
            @(negedge clk);
            nu += int'(pump_up);
            nd += int'(pump_dn);
            both += int'(pump_up & pump_dn);
            if (k == m) begin
                if (d > 0) fb_in = 1'b1;
                else ref_in = 1'b1;
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            nu += int'(pump_up);
            nd += int'(pump_dn);
            both += int'(pump_up & pump_dn);
        end
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nu, nd, both;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 up", int'(pump_up), 0);
        chk("R1 dn", int'(pump_dn), 0);
        chk("R1 en", int'(pump_en), 1);
        chk("R1 lock", int'(shared_out), 0);

        // Vector table: pulse width and polarity (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            invert = VECS[i].inv;
            pulse(VECS[i].d, nu, nd, both);
            chk($sformatf("R%0d up width v%0d", VECS[i].req, i), nu, VECS[i].up_w);
            chk($sformatf("R%0d dn width v%0d", VECS[i].req, i), nd, VECS[i].dn_w);
            chk("R3 never both", both, 0);
        end
        invert = 1'b0;

        // R6 lock after LOCK_COUNT reference edges
        do_reset();
        for (int i = 0; i < LOCK_COUNT - 1; i++) pulse(1, nu, nd, both);
        chk("R6 not yet locked", int'(shared_out), 0);
        pulse(1, nu, nd, both);
        chk("R6 locked", int'(shared_out), 1);
        // R10 pulse at the limit keeps lock
        pulse(MAX_W, nu, nd, both);
        chk("R10 width at limit", nu, MAX_W);
        chk("R10 lock kept", int'(shared_out), 1);
        // R7 pulse one past the limit drops lock
        pulse(MAX_W + 1, nu, nd, both);
        chk("R7 lock dropped", int'(shared_out), 0);
        pulse(1, nu, nd, both);
        chk("R7 count restarted", int'(shared_out), 0);

        // R8 sleep clears lock
        for (int i = 0; i < LOCK_COUNT; i++) pulse(1, nu, nd, both);
        chk("R6 relocked", int'(shared_out), 1);
        sleep = 1'b1;
        @(negedge clk);
        chk("R8 lock cleared", int'(shared_out), 0);
        chk("R5 pump disabled", int'(pump_en), 0);
        // R5 edge during sleep ignored
        ref_in = 1'b1;
        @(negedge clk);
        chk("R5 up silent in sleep", int'(pump_up), 0);
        sleep = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 no pulse after wake", int'(pump_up), 0);
        chk("R5 pump enabled", int'(pump_en), 1);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
        // R5 pulse in progress discarded
        ref_in = 1'b1;
        @(negedge clk);
        chk("R2 up open", int'(pump_up), 1);
        sleep = 1'b1;
        @(negedge clk);
        chk("R5 up forced low", int'(pump_up), 0);
        sleep = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 open pulse discarded", int'(pump_up), 0);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);

        // R9 monitor selection
        mon_sel = 1'b1;
        mon_src = 1'b0;
        ref_in = 1'b1;
        #1;
        chk("R9 shows ref high", int'(shared_out), 1);
        ref_in = 1'b0;
        #1;
        chk("R9 shows ref low", int'(shared_out), 0);
        mon_src = 1'b1;
        fb_in = 1'b1;
        #1;
        chk("R9 shows fb high", int'(shared_out), 1);
        fb_in = 1'b0;
        ref_in = 1'b1;
        #1;
        chk("R9 fb view ignores ref", int'(shared_out), 0);
        ref_in = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule